// File: doc/BRIEF.md
# CD Serial Byte Receiver

This block sits behind the serial output of a CD decoder front end. It watches a bit clock, a word-select line, a data line and a per-sample error flag, all sampled by the system clock, and turns each 16-bit serial word into two bytes on a byte bus with a valid strobe. The bit clock is oversampled: the block counts its sampling edges and takes one data bit per group of 1, 2, 4 or 8 edges. The sampling edge can be the rising or the falling one, and the framing follows either the I2S convention (word starts one bit after the word-select change) or the EIAJ convention (word starts on the word-select change).

A sector counter runs over the emitted bytes and marks the byte that closes each sector with a one-cycle end pulse. The sector length is either the full raw sector (sync, header, sub-header and user data, 2352 bytes by default) or a shorter length (2064 by default), optionally counting only bytes whose error flag was clear. A sync pulse from the sync detector restarts the count.

All options come from one write-only control byte. A write is held as pending and only becomes active at a sector boundary (counter wrap) or a sync pulse, so the sector in progress keeps its settings. One control bit, which selects whether one or both sub-header copies feed the sub-header error status, is passed out for the status logic.

Top module: `cdrx_receiver`

## Requirements
- R1: Control bit 7 picks the framing. At 0 (I2S) the most significant bit of a word is the bit sampled one bit period after word-select changes; at 1 (EIAJ) it is the bit sampled in the first bit period with the new word-select level. Words are 16 bits, sent most significant bit first.
- R2: Control bits 6:5 set how many sampling edges make one bit period: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 1.
- R3: With control bit 0 clear, bits are sampled on rising bit-clock edges; with it set, on falling edges.
- R4: With control bit 1 clear, each word is emitted upper byte (bits 15:8) first; with it set, lower byte (bits 7:0) first.
- R5: Control bits 3:2 pick the sector length: 00 uses LONG_COUNT bytes, 01 uses SHORT_COUNT bytes, and 11 behaves exactly as 00.
- R6: Code 10 in control bits 3:2 uses SHORT_COUNT but does not count bytes whose error flag is set; the flag is sampled with the last bit of a word and applies to both of its bytes, which are still emitted.
- R7: `sectorEnd` is high for exactly one cycle, together with the `byteValid` of the counted byte that brings the count to the selected length; the count then restarts at zero.
- R8: A `syncIn` pulse resets the sector count to zero without producing `sectorEnd`, and makes the pending control byte active.
- R9: A control write does not change any active setting until the next sector end or sync pulse.
- R10: `subHdrFirstOnly` shows active control bit 4.
- R11: After reset no byte is emitted, `sectorEnd` is low and the active and pending control bytes are zero.
- R12: Each completed word yields exactly two `byteValid` cycles, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Write strobe for the control byte |
| cfgData | input | 8 | Control byte value |
| syncIn | input | 1 | Sector sync pulse from the sync detector |
| bitClkIn | input | 1 | Oversampled serial bit clock |
| wsIn | input | 1 | Serial word select |
| serData | input | 1 | Serial data bit |
| errIn | input | 1 | Error flag accompanying the serial data |
| byteData | output | 8 | Received byte |
| byteValid | output | 1 | `byteData` holds a new byte this cycle |
| sectorEnd | output | 1 | This byte closes a sector |
| subHdrFirstOnly | output | 1 | Sub-header status source selection (active bit 4) |

## Verification
The assertions assume a bit clock whose edges are at least two system cycles apart, with data, word select and flag changing only on the non-sampling half, and a sync pulse that never lands on a byte emission. The bench keeps to this by holding each bit-clock level for two cycles, updating the serial lines on the non-sampling edge, and stopping the bit clock whenever it reconfigures or pulses sync, so the idle-level change after a polarity switch is never a sampling edge. Mid-sector writes in the bench alter only length, swap and sub-header selection, and every word count keeps counted bytes even so wraps fall on the second byte of a word.

// File: rtl/cdrx_pkg.sv
package cdrx_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // sector length selection; code values are fixed by the control byte layout
  typedef enum logic [1:0] {
    MOD_LONG  = 2'b00,
    MOD_SHORT = 2'b01,
    MOD_SKIP  = 2'b10,
    MOD_RSVD  = 2'b11
  } modSel_e;

  // control byte, bit 7 first
  typedef struct packed {
    logic       eiaj;
    logic [1:0] clkDiv;
    logic       subFirst;
    modSel_e    modSel;
    logic       swap;
    logic       invClk;
  } rxCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic bitStb;
    logic wordDone;
  } rxStb_t;

endpackage

// File: rtl/cdrx_ctrl.sv
module cdrx_ctrl
  import cdrx_pkg::*;
#(
  parameter int WORD_BITS = WORD_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWr,
  input  logic [7:0] cfgData,
  input  logic    syncIn,
  input  logic    sectorWrap,
  input  logic    bitClkIn,
  input  logic    wsIn,
  output rxStb_t  stb,
  output logic    swapEn,
  output modSel_e modSel,
  output logic    subFirst
);

  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  rxCfg_t cfgPend, cfgAct;
  logic   applyCfg;
  logic   bitClkQ, sampEdge, bitStb;
  logic [2:0] divCnt, divLast;
  logic   ws1, ws2, boundary;
  logic   armed;
  logic [CNT_W-1:0] bitCnt;
  logic   wordDone;

  assign applyCfg = syncIn | sectorWrap;

  // pending / active control byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPend <= '0;
      cfgAct  <= '0;
    end else begin
      if (cfgWr)    cfgPend <= rxCfg_t'(cfgData);
      if (applyCfg) cfgAct  <= cfgPend;
    end
  end

  // sampling edge of the bit clock, polarity selectable
  always_ff @(posedge clk) begin
    if (!rstN) bitClkQ <= 1'b0;
    else       bitClkQ <= bitClkIn;
  end

  assign sampEdge = cfgAct.invClk ? (~bitClkIn & bitClkQ) : (bitClkIn & ~bitClkQ);

  // edge divider
  always_comb begin
    case (cfgAct.clkDiv)
      2'b00:   divLast = 3'd1;
      2'b01:   divLast = 3'd3;
      2'b10:   divLast = 3'd7;
      default: divLast = 3'd0;
    endcase
  end

  assign bitStb = sampEdge && (divCnt == divLast);

  always_ff @(posedge clk) begin
    if (!rstN)         divCnt <= '0;
    else if (applyCfg) divCnt <= '0;
    else if (sampEdge) divCnt <= (divCnt == divLast) ? 3'd0 : divCnt + 3'd1;
  end

  // word-select history at bit strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ws1 <= 1'b0;
      ws2 <= 1'b0;
    end else if (bitStb) begin
      ws1 <= wsIn;
      ws2 <= ws1;
    end
  end

  // I2S: boundary one bit after the change; EIAJ: on the change
  assign boundary = bitStb && (cfgAct.eiaj ? (wsIn != ws1) : (ws1 != ws2));
  assign wordDone = bitStb && !boundary && armed && (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      bitCnt <= '0;
    end else if (boundary) begin
      armed  <= 1'b1;
      bitCnt <= CNT_W'(1);
    end else if (bitStb && armed) begin
      if (wordDone) armed <= 1'b0;
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign stb.bitStb   = bitStb;
  assign stb.wordDone = wordDone;
  assign swapEn       = cfgAct.swap;
  assign modSel       = cfgAct.modSel;
  assign subFirst     = cfgAct.subFirst;

endmodule

// File: rtl/cdrx_datapath.sv
module cdrx_datapath
  import cdrx_pkg::*;
#(
  parameter int LONG_COUNT  = 2352,
  parameter int SHORT_COUNT = 2064
) (
  input  logic        clk,
  input  logic        rstN,
  input  rxStb_t      stb,
  input  logic        serData,
  input  logic        errIn,
  input  logic        syncIn,
  input  logic        swapEn,
  input  modSel_e     modSel,
  output logic [BYTE_W-1:0] byteData,
  output logic        byteValid,
  output logic        sectorEnd,
  output logic        sectorWrap
);

  localparam int MAX_COUNT = (LONG_COUNT > SHORT_COUNT) ? LONG_COUNT : SHORT_COUNT;
  localparam int SC_W = $clog2(MAX_COUNT);
  localparam logic [SC_W-1:0] LONG_LAST  = SC_W'(LONG_COUNT - 1);
  localparam logic [SC_W-1:0] SHORT_LAST = SC_W'(SHORT_COUNT - 1);

  logic [WORD_W-1:0] shiftReg, nextWord;
  logic [BYTE_W-1:0] hiByte, loByte, holdByte, emitByte;
  logic holdFlag, secondPend, emitNow, emitFlag, counted, wrap;
  logic [SC_W-1:0] secCnt, modLast;

  assign nextWord = {shiftReg[WORD_W-2:0], serData};
  assign hiByte   = nextWord[WORD_W-1 -: BYTE_W];
  assign loByte   = nextWord[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)           shiftReg <= '0;
    else if (stb.bitStb) shiftReg <= nextWord;
  end

  // second byte of a word waits one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte   <= '0;
      holdFlag   <= 1'b0;
      secondPend <= 1'b0;
    end else begin
      secondPend <= stb.wordDone;
      if (stb.wordDone) begin
        holdByte <= swapEn ? hiByte : loByte;
        holdFlag <= errIn;
      end
    end
  end

  assign emitNow  = stb.wordDone | secondPend;
  assign emitByte = stb.wordDone ? (swapEn ? loByte : hiByte) : holdByte;
  assign emitFlag = stb.wordDone ? errIn : holdFlag;

  // sector counter
  always_comb begin
    case (modSel)
      MOD_SHORT, MOD_SKIP: modLast = SHORT_LAST;
      default:             modLast = LONG_LAST;
    endcase
  end

  assign counted = emitNow && !((modSel == MOD_SKIP) && emitFlag);
  assign wrap    = counted && !syncIn && (secCnt == modLast);

  always_ff @(posedge clk) begin
    if (!rstN)        secCnt <= '0;
    else if (syncIn)  secCnt <= '0;
    else if (wrap)    secCnt <= '0;
    else if (counted) secCnt <= secCnt + SC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteData  <= '0;
      byteValid <= 1'b0;
      sectorEnd <= 1'b0;
    end else begin
      byteValid <= emitNow;
      sectorEnd <= wrap;
      if (emitNow) byteData <= emitByte;
    end
  end

  assign sectorWrap = wrap;

endmodule

// File: rtl/cdrx_receiver.sv
module cdrx_receiver
  import cdrx_pkg::*;
#(
  parameter int LONG_COUNT  = 2352,
  parameter int SHORT_COUNT = 2064
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [7:0] cfgData,
  input  logic       syncIn,
  input  logic       bitClkIn,
  input  logic       wsIn,
  input  logic       serData,
  input  logic       errIn,
  output logic [7:0] byteData,
  output logic       byteValid,
  output logic       sectorEnd,
  output logic       subHdrFirstOnly
);

  rxStb_t  stb;
  logic    swapEn, sectorWrap;
  modSel_e modSel;

  cdrx_ctrl #(.WORD_BITS(WORD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgData   (cfgData),
    .syncIn    (syncIn),
    .sectorWrap(sectorWrap),
    .bitClkIn  (bitClkIn),
    .wsIn      (wsIn),
    .stb       (stb),
    .swapEn    (swapEn),
    .modSel    (modSel),
    .subFirst  (subHdrFirstOnly)
  );

  cdrx_datapath #(.LONG_COUNT(LONG_COUNT), .SHORT_COUNT(SHORT_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .serData   (serData),
    .errIn     (errIn),
    .syncIn    (syncIn),
    .swapEn    (swapEn),
    .modSel    (modSel),
    .byteData  (byteData),
    .byteValid (byteValid),
    .sectorEnd (sectorEnd),
    .sectorWrap(sectorWrap)
  );

endmodule

// File: rtl/cdrx_receiver_chk.sv
module cdrx_receiver_chk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic sectorEnd,
  input logic syncIn,
  input logic subHdrFirstOnly
);

  assert_end_on_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    sectorEnd |-> byteValid);

  assert_end_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    sectorEnd |=> !sectorEnd);

  assert_pair_second_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteValid) |=> byteValid);

  assert_pair_limit_R12: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && $past(byteValid)) |=> !byteValid);

  assert_cfg_boundary_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(subHdrFirstOnly) |-> (sectorEnd || $past(syncIn)));

endmodule

bind cdrx_receiver cdrx_receiver_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .byteValid      (byteValid),
  .sectorEnd      (sectorEnd),
  .syncIn         (syncIn),
  .subHdrFirstOnly(subHdrFirstOnly)
);

// File: tb/sim_cdrx_receiver.sv
module sim_cdrx_receiver;

  localparam int LONG_N  = 24;
  localparam int SHORT_N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [7:0] cfgData = '0;
  logic syncIn = 1'b0;
  logic bitClkIn = 1'b0;
  logic wsIn = 1'b0;
  logic serData = 1'b0;
  logic errIn = 1'b0;
  logic [7:0] byteData;
  logic byteValid, sectorEnd, subHdrFirstOnly;

  always #5 clk = ~clk;

  cdrx_receiver #(.LONG_COUNT(LONG_N), .SHORT_COUNT(SHORT_N)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData), .syncIn(syncIn),
    .bitClkIn(bitClkIn), .wsIn(wsIn), .serData(serData), .errIn(errIn),
    .byteData(byteData), .byteValid(byteValid), .sectorEnd(sectorEnd),
    .subHdrFirstOnly(subHdrFirstOnly)
  );

  int total = 0;
  int failed = 0;
  bit finished = 0;
  string curReq = "R11";

  // reference model state
  logic [7:0] mAct = '0;
  logic [7:0] mPend = '0;
  int mCnt = 0;
  logic lastWs = 1'b0;
  byte unsigned expData[$];
  bit expEnd[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input int seed, input int i);
    return 16'(seed * 16'h0097 + i * 16'h3b1d + 16'h0a5f);
  endfunction

  function automatic bit flagOf(input int i, input int every);
    return (every > 0) && ((i % every) == every - 1);
  endfunction

  task automatic pushByte(input logic [7:0] b, input bit f);
    bit isEnd = 0;
    int lastIdx;
    if (!(mAct[3:2] == 2'b10 && f)) begin
      lastIdx = (mAct[3:2] == 2'b01 || mAct[3:2] == 2'b10) ? SHORT_N - 1 : LONG_N - 1;
      if (mCnt == lastIdx) begin
        isEnd = 1;
        mCnt = 0;
        mAct = mPend;
      end else begin
        mCnt++;
      end
    end
    expData.push_back(b);
    expEnd.push_back(isEnd);
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (byteValid) begin
        if (expData.size() == 0) begin
          check(0, "R12", "byte with none expected", byteData, -1);
        end else begin
          byte unsigned d;
          bit e;
          d = expData.pop_front();
          e = expEnd.pop_front();
          check(byteData == d, curReq, "byte value", byteData, d);
          check(sectorEnd == e, "R7", "sector end with byte", sectorEnd, e);
        end
      end else begin
        check(sectorEnd == 1'b0, "R7", "sector end without byte", sectorEnd, 0);
      end
    end
  end

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWr = 1'b1;
    cfgData = v;
    @(negedge clk);
    cfgWr = 1'b0;
    mPend = v;
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    mCnt = 0;
    mAct = mPend;
    repeat (2) @(negedge clk);
    bitClkIn = mAct[0];  // idle level is the non-sampling level
  endtask

  task automatic sendSeg(input int nWords, input int flagEvery, input int seed, input string req);
    logic [7:0] c;
    bit eiaj;
    int edgesPerBit, nSlots;
    logic samp, wsBase;
    c = mAct;
    eiaj = c[7];
    case (c[6:5])
      2'b00:   edgesPerBit = 2;
      2'b01:   edgesPerBit = 4;
      2'b10:   edgesPerBit = 8;
      default: edgesPerBit = 1;
    endcase
    samp = ~c[0];
    wsBase = ~lastWs;
    curReq = req;
    for (int i = 0; i < nWords; i++) begin
      logic [15:0] w;
      bit f;
      w = wordOf(seed, i);
      f = flagOf(i, flagEvery);
      if (mAct[1]) begin
        pushByte(w[7:0], f);
        pushByte(w[15:8], f);
      end else begin
        pushByte(w[15:8], f);
        pushByte(w[7:0], f);
      end
    end
    nSlots = eiaj ? 16 * nWords : 16 * nWords + 1;
    for (int s = 0; s < nSlots; s++) begin
      int wi, bi;
      logic [15:0] w;
      logic wsv;
      wsv = wsBase ^ logic'((s / 16) % 2);
      if (eiaj) begin
        wi = s / 16;
        bi = 15 - (s % 16);
      end else if (s == 0) begin
        wi = -1;
        bi = 0;
      end else begin
        wi = (s - 1) / 16;
        bi = 15 - ((s - 1) % 16);
      end
      wsIn = wsv;
      if (wi < 0) begin
        serData = 1'b0;
        errIn = 1'b0;
      end else begin
        w = wordOf(seed, wi);
        serData = w[bi];
        errIn = flagOf(wi, flagEvery);
      end
      repeat (edgesPerBit) begin
        @(negedge clk);
        bitClkIn = samp;
        repeat (2) @(negedge clk);
        bitClkIn = ~samp;
        @(negedge clk);
      end
      lastWs = wsv;
    end
    repeat (8) @(negedge clk);
    check(expData.size() == 0, req, "bytes still expected", expData.size(), 0);
    check(subHdrFirstOnly == mAct[4], "R10", "sub-header select after segment", subHdrFirstOnly, mAct[4]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(byteValid == 1'b0, "R11", "valid after reset", byteValid, 0);
    check(sectorEnd == 1'b0, "R11", "sector end after reset", sectorEnd, 0);
    check(subHdrFirstOnly == 1'b0, "R11", "sub-header select after reset", subHdrFirstOnly, 0);

    // defaults: I2S, 2 edges per bit, long sector, no swap
    sendSeg(16, 0, 1, "R1 R2 R5 R12");

    // EIAJ, 4 edges per bit, swap, short sector, sub-header bit set
    writeCfg(8'hB6);
    repeat (3) @(negedge clk);
    check(subHdrFirstOnly == 1'b0, "R9", "write held before boundary", subHdrFirstOnly, 0);
    pulseSync();
    check(subHdrFirstOnly == 1'b1, "R8", "sync applies pending byte", subHdrFirstOnly, 1);
    sendSeg(12, 0, 2, "R1 R4 R5");

    // I2S, inverted clock, no division, flagged bytes skipped
    writeCfg(8'h79);
    pulseSync();
    sendSeg(20, 3, 3, "R3 R6 R2");

    // EIAJ, 8 edges per bit, reserved length code, sub-header bit clear
    writeCfg(8'hCC);
    pulseSync();
    check(subHdrFirstOnly == 1'b0, "R10", "sub-header select cleared", subHdrFirstOnly, 0);
    sendSeg(14, 0, 4, "R5 R2");

    // mid-sector write: short length, swap, sub-header bit, only after wrap
    writeCfg(8'hD6);
    repeat (3) @(negedge clk);
    check(subHdrFirstOnly == 1'b0, "R9", "mid-sector write not yet active", subHdrFirstOnly, 0);
    sendSeg(12, 0, 5, "R9 R4");

    // sync with a partial count must restart the sector
    pulseSync();
    sendSeg(8, 0, 6, "R8 R7");

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R12", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule